// File: doc/BRIEF.md
# Four-Error ECC Correction Sequencer

This block runs the read-side correction flow for a sector protected by a four-error syndrome engine. It is given the ten ECC bytes stored with a 512-byte sector. It unpacks them into eight 10-bit check values and loads them into the engine. It reads back the syndrome words, and if they are not all zero it starts the engine's error-location step. When the engine reports its results, the block walks through up to four address/value reports and issues one XOR fix per report that lands inside the sector buffer.

The engine is reached through a simple request/acknowledge register port. The sector buffer is reached through a one-cycle fix strobe that carries a byte index and an XOR mask; the buffer owner applies that mask in one read-modify-write cycle. The engine's Reed-Solomon arithmetic lies outside this block. At the end the block reports the number of bytes it corrected and whether the sector is uncorrectable, and pulses done.

Top module: `ecc4_fix_seq`

## Requirements
- R1: If all ten stored ECC bytes are 0xFF, the sector is taken as erased. Done follows with corrected = 0, uncorrectable = 0, and no engine access at all.
- R2: The ECC byte vector (byte 0 in bits [7:0]) is a bit stream, and check value k is stream bits [10k+9:10k]. The eight values are written to engine select 0 in the low bits of the write data, value 7 first and value 0 last. A vector with even one byte other than 0xFF is loaded.
- R3: After loading, the block reads selects 1 to 4, keeping only fields [9:0] and [25:16] of each. If every kept field is zero, done follows with corrected = 0, and select 10 is never written.
- R4: Before the location step starts, the block reads select 6. The access right after that read is a write of select 10 with bit 0 set.
- R5: After the start, the block reads the status at select 5, whose state field is bits [11:8]. While the state is below 4 it keeps waiting, up to TIMEOUT_CYC cycles. A state below 4 seen in that window is not taken as a result. When the window expires the block moves on to polling, where states 0 to 3 are final and 4 and above mean busy.
- R6: Final state 0 or 1 leads to one read of select 8 and then done with corrected = 0. State 1 sets uncorrectable and state 0 clears it.
- R7: Final state 2 or 3 gives an error count of 1 plus status bits [17:16]. Errors 0 and 1 read selects 6 (address) and 8 (value), and errors 2 and 3 read selects 7 and 9, in that order. An even-numbered error takes address bits [9:0] and value bits [7:0]; an odd-numbered error takes bits [25:16] and [23:16].
- R8: Each address maps to byte index 519 minus the address. Only an index below 512 is fixed, and only fixed errors add to corrected.
- R9: Done is a one-cycle pulse. Corrected and uncorrectable hold until the next start. An engine request is held with a stable select until it is acknowledged.
- R10: Each applied error produces exactly one one-cycle fix strobe with its index and value mask, and fix strobes are never back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a correction run (taken when idle) |
| eccBytes | input | 80 | Ten stored ECC bytes, byte 0 in [7:0] |
| engReq | output | 1 | Engine access request |
| engWe | output | 1 | Engine access is a write |
| engAddr | output | 4 | Engine register select |
| engWdata | output | 32 | Engine write data |
| engAck | input | 1 | Engine access complete; read data valid |
| engRdata | input | 32 | Engine read data |
| bufFixValid | output | 1 | Apply a fix to the buffer this cycle |
| bufFixIdx | output | 9 | Byte index of the fix |
| bufFixMask | output | 8 | XOR mask for the byte |
| done | output | 1 | Run finished (one cycle) |
| corrected | output | 3 | Number of bytes fixed |
| uncorrectable | output | 1 | Engine reported five or more errors |

## Verification
The engine model gives state 3 right after the start, before any busy state. A sequencer that polled at once would then read the error registers early, and the bench flags such reads. A second run never shows a busy state, so a sequencer without the timeout would hang, and one with no wait would finish after far fewer status reads. Four-error runs use addresses that map to index 512 and to a negative index, and put junk in the bits outside each field. A sequencer that mis-masked, swapped the register halves or counted skipped errors would change the wrong bytes or report the wrong count. Other runs cover erased and nearly erased vectors, zero syndromes and the two final states that end without a fix, each checked for its required register access order.

// File: rtl/ecc4_pkg.sv
package ecc4_pkg;

  localparam int ENG_W      = 32;
  localparam int FIELD_W    = 10;
  localparam int HALF_LSB   = 16;
  localparam int ST_LSB     = 8;
  localparam int ST_W       = 4;
  localparam int CNT_LSB    = 16;
  localparam int START_BIT  = 0;
  localparam int MAX_ERR    = 4;
  localparam int CNT_W      = $clog2(MAX_ERR + 1);
  localparam int NUM_SYN    = 4;

  typedef enum logic [3:0] {
    SEL_LOAD   = 4'd0,
    SEL_SYN0   = 4'd1,
    SEL_STATUS = 4'd5,
    SEL_EADDR1 = 4'd6,
    SEL_EADDR2 = 4'd7,
    SEL_EVAL1  = 4'd8,
    SEL_EVAL2  = 4'd9,
    SEL_CTRL   = 4'd10
  } engSel_e;

  typedef struct packed {
    logic latchBytes;
    logic clrRun;
    logic accSyn;
    logic capStatus;
    logic capAddr;
    logic capVal;
    logic errOdd;
    logic applyFix;
    logic setUncorr;
    logic sendStart;
  } ctlStrobe_t;

endpackage

// File: rtl/ecc4_dp.sv
module ecc4_dp
  import ecc4_pkg::*;
#(
  parameter int NUM_VALS   = 8,
  parameter int VAL_W      = 10,
  parameter int DATA_BYTES = 512
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  ctlStrobe_t                     ctl,
  input  logic [$clog2(NUM_VALS)-1:0]    loadIdx,
  input  logic [NUM_VALS*VAL_W-1:0]      eccBytes,
  input  logic [ENG_W-1:0]               engRdata,
  output logic [ENG_W-1:0]               engWdata,
  output logic                           isErased,
  output logic                           synZero,
  output logic [ST_W-1:0]                rdState,
  output logic [CNT_W-1:0]               numErr,
  output logic                           bufFixValid,
  output logic [$clog2(DATA_BYTES)-1:0]  bufFixIdx,
  output logic [7:0]                     bufFixMask,
  output logic [CNT_W-1:0]               corrected,
  output logic                           uncorrectable
);

  localparam int ECC_BITS  = NUM_VALS * VAL_W;
  localparam int IDX_W     = $clog2(DATA_BYTES);
  localparam int ADDR_BIAS = DATA_BYTES + 7;
  localparam int CALC_W    = $clog2(ADDR_BIAS + 1) + 1;

  logic [ECC_BITS-1:0] bytesQ;
  logic [VAL_W-1:0]    vals [NUM_VALS];
  logic                synHit;
  logic [FIELD_W-1:0]  addrQ;
  logic [7:0]          valQ;
  logic [CALC_W-1:0]   diff;
  logic                inRange;
  logic                unusedRd;

  assign unusedRd = ^{engRdata[31:26], engRdata[15:12]};

  for (genvar k = 0; k < NUM_VALS; k++) begin : g_unpack
    assign vals[k] = bytesQ[k*VAL_W +: VAL_W];
  end

  assign isErased = &bytesQ;
  assign synZero  = !synHit;
  assign rdState  = engRdata[ST_LSB +: ST_W];
  assign engWdata = ctl.sendStart ? (ENG_W'(1) << START_BIT) : ENG_W'(vals[loadIdx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bytesQ <= '0;
    end else if (ctl.latchBytes) begin
      bytesQ <= eccBytes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.clrRun) begin
      synHit <= 1'b0;
    end else if (ctl.accSyn) begin
      synHit <= synHit | (|engRdata[FIELD_W-1:0]) | (|engRdata[HALF_LSB +: FIELD_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      numErr <= '0;
    end else if (ctl.capStatus) begin
      numErr <= CNT_W'(engRdata[CNT_LSB +: 2]) + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ <= '0;
      valQ  <= '0;
    end else begin
      if (ctl.capAddr)
        addrQ <= ctl.errOdd ? engRdata[HALF_LSB +: FIELD_W] : engRdata[FIELD_W-1:0];
      if (ctl.capVal)
        valQ <= ctl.errOdd ? engRdata[HALF_LSB +: 8] : engRdata[7:0];
    end
  end

  assign diff        = CALC_W'(ADDR_BIAS) - CALC_W'(addrQ);
  assign inRange     = !diff[CALC_W-1] && (diff < CALC_W'(DATA_BYTES));
  assign bufFixValid = ctl.applyFix && inRange;
  assign bufFixIdx   = diff[IDX_W-1:0];
  assign bufFixMask  = valQ;

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.clrRun) begin
      corrected     <= '0;
      uncorrectable <= 1'b0;
    end else begin
      if (bufFixValid) corrected <= corrected + CNT_W'(1);
      if (ctl.setUncorr) uncorrectable <= 1'b1;
    end
  end

  AST_FIX_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    bufFixValid |=> !bufFixValid); // R10
  AST_CORR_LE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    corrected <= numErr); // R8
  AST_UNCORR_NOFIX: assert property (@(posedge clk) disable iff (!rst_n)
    uncorrectable |-> corrected == '0); // R6

endmodule

// File: rtl/ecc4_ctrl.sv
module ecc4_ctrl
  import ecc4_pkg::*;
#(
  parameter int NUM_VALS    = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         engAck,
  input  logic                         isErased,
  input  logic                         synZero,
  input  logic [ST_W-1:0]              rdState,
  input  logic [CNT_W-1:0]             numErr,
  output logic                         engReq,
  output logic                         engWe,
  output logic [3:0]                   engAddr,
  output ctlStrobe_t                   ctl,
  output logic [$clog2(NUM_VALS)-1:0]  loadIdx,
  output logic                         done
);

  localparam int LIDX_W = $clog2(NUM_VALS);
  localparam int TMR_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int SYN_W  = $clog2(NUM_SYN);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_LOAD, S_SYN, S_SYNCHK, S_CLR, S_START,
    S_WAIT, S_POLL, S_FLUSH, S_FADDR, S_FVAL, S_FAPPLY, S_DONE
  } state_e;

  state_e           state;
  logic [SYN_W-1:0] synIdx;
  logic [CNT_W-1:0] errIdx;
  logic [TMR_W-1:0] tmr;
  logic             rdFinal;

  assign rdFinal = rdState < ST_W'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      loadIdx <= '0;
      synIdx  <= '0;
      errIdx  <= '0;
      tmr     <= '0;
    end else begin
      case (state)
        S_IDLE:  if (start) state <= S_CHECK;
        S_CHECK: begin
          loadIdx <= LIDX_W'(NUM_VALS - 1);
          state   <= isErased ? S_DONE : S_LOAD;
        end
        S_LOAD: if (engAck) begin
          if (loadIdx == '0) begin
            synIdx <= '0;
            state  <= S_SYN;
          end else begin
            loadIdx <= loadIdx - LIDX_W'(1);
          end
        end
        S_SYN: if (engAck) begin
          if (synIdx == SYN_W'(NUM_SYN - 1)) state <= S_SYNCHK;
          else synIdx <= synIdx + SYN_W'(1);
        end
        S_SYNCHK: state <= synZero ? S_DONE : S_CLR;
        S_CLR:    if (engAck) state <= S_START;
        S_START: if (engAck) begin
          tmr   <= '0;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (tmr != TMR_W'(TIMEOUT_CYC)) tmr <= tmr + TMR_W'(1);
          if (engAck && (!rdFinal || tmr == TMR_W'(TIMEOUT_CYC))) state <= S_POLL;
        end
        S_POLL: if (engAck && rdFinal) begin
          errIdx <= '0;
          state  <= (rdState < ST_W'(2)) ? S_FLUSH : S_FADDR;
        end
        S_FLUSH: if (engAck) state <= S_DONE;
        S_FADDR: if (engAck) state <= S_FVAL;
        S_FVAL:  if (engAck) state <= S_FAPPLY;
        S_FAPPLY: begin
          if (errIdx + CNT_W'(1) == numErr) state <= S_DONE;
          else begin
            errIdx <= errIdx + CNT_W'(1);
            state  <= S_FADDR;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    engReq = 1'b0;
    engWe  = 1'b0;
    engAddr = SEL_STATUS;
    case (state)
      S_LOAD:  begin engReq = 1'b1; engWe = 1'b1; engAddr = SEL_LOAD; end
      S_SYN:   begin engReq = 1'b1; engAddr = 4'(SEL_SYN0) + 4'(synIdx); end
      S_CLR:   begin engReq = 1'b1; engAddr = SEL_EADDR1; end
      S_START: begin engReq = 1'b1; engWe = 1'b1; engAddr = SEL_CTRL; end
      S_WAIT, S_POLL: begin engReq = 1'b1; engAddr = SEL_STATUS; end
      S_FLUSH: begin engReq = 1'b1; engAddr = SEL_EVAL1; end
      S_FADDR: begin engReq = 1'b1; engAddr = errIdx[1] ? SEL_EADDR2 : SEL_EADDR1; end
      S_FVAL:  begin engReq = 1'b1; engAddr = errIdx[1] ? SEL_EVAL2 : SEL_EVAL1; end
      default: ;
    endcase
  end

  always_comb begin
    ctl            = '0;
    ctl.latchBytes = (state == S_IDLE) && start;
    ctl.clrRun     = (state == S_IDLE) && start;
    ctl.accSyn     = (state == S_SYN) && engAck;
    ctl.capStatus  = (state == S_POLL) && engAck && rdFinal && (rdState >= ST_W'(2));
    ctl.setUncorr  = (state == S_POLL) && engAck && (rdState == ST_W'(1));
    ctl.capAddr    = (state == S_FADDR) && engAck;
    ctl.capVal     = (state == S_FVAL) && engAck;
    ctl.errOdd     = errIdx[0];
    ctl.applyFix   = (state == S_FAPPLY);
    ctl.sendStart  = (state == S_START);
  end

  assign done = (state == S_DONE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    engReq && !engAck |=> engReq && $stable(engAddr) && $stable(engWe)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ERASED_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK) && isErased |=> !engReq && done); // R1
  AST_START_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START) |-> engWe && (engAddr == SEL_CTRL)); // R4

endmodule

// File: rtl/ecc4_fix_seq.sv
module ecc4_fix_seq
  import ecc4_pkg::*;
#(
  parameter int NUM_VALS    = 8,
  parameter int VAL_W       = 10,
  parameter int DATA_BYTES  = 512,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [NUM_VALS*VAL_W-1:0]      eccBytes,
  output logic                           engReq,
  output logic                           engWe,
  output logic [3:0]                     engAddr,
  output logic [31:0]                    engWdata,
  input  logic                           engAck,
  input  logic [31:0]                    engRdata,
  output logic                           bufFixValid,
  output logic [$clog2(DATA_BYTES)-1:0]  bufFixIdx,
  output logic [7:0]                     bufFixMask,
  output logic                           done,
  output logic [2:0]                     corrected,
  output logic                           uncorrectable
);

  ctlStrobe_t                    ctl;
  logic [$clog2(NUM_VALS)-1:0]   loadIdx;
  logic                          isErased;
  logic                          synZero;
  logic [ST_W-1:0]               rdState;
  logic [CNT_W-1:0]              numErr;

  ecc4_ctrl #(.NUM_VALS(NUM_VALS), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .engAck(engAck),
    .isErased(isErased), .synZero(synZero), .rdState(rdState), .numErr(numErr),
    .engReq(engReq), .engWe(engWe), .engAddr(engAddr), .ctl(ctl),
    .loadIdx(loadIdx), .done(done)
  );

  ecc4_dp #(.NUM_VALS(NUM_VALS), .VAL_W(VAL_W), .DATA_BYTES(DATA_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .loadIdx(loadIdx), .eccBytes(eccBytes),
    .engRdata(engRdata), .engWdata(engWdata), .isErased(isErased), .synZero(synZero),
    .rdState(rdState), .numErr(numErr), .bufFixValid(bufFixValid),
    .bufFixIdx(bufFixIdx), .bufFixMask(bufFixMask), .corrected(corrected),
    .uncorrectable(uncorrectable)
  );

endmodule

// File: tb/sim_ecc4_fix_seq.sv
module sim_ecc4_fix_seq;

  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [79:0] eccIn = '0;
  logic engReq, engWe, engAck, bufFixValid, done, uncorrectable;
  logic [3:0] engAddr;
  logic [31:0] engWdata, engRdata;
  logic [8:0] bufFixIdx;
  logic [7:0] bufFixMask;
  logic [2:0] corrected;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc4_fix_seq #(.TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .eccBytes(eccIn),
    .engReq(engReq), .engWe(engWe), .engAddr(engAddr), .engWdata(engWdata),
    .engAck(engAck), .engRdata(engRdata), .bufFixValid(bufFixValid),
    .bufFixIdx(bufFixIdx), .bufFixMask(bufFixMask), .done(done),
    .corrected(corrected), .uncorrectable(uncorrectable)
  );

  int nChecks = 0;
  int nErr = 0;

  // engine model state
  logic [31:0] synReg [4];
  logic [31:0] addrReg [2];
  logic [31:0] valReg [2];
  logic [3:0]  seq [8];
  int          seqLen;
  logic [3:0]  finalSt;
  logic [1:0]  cntField;
  bit          started, termSeen;
  int          stIdx, statusReads, earlyRead;
  logic [3:0]  logSel [256];
  bit          logWe [256];
  logic [31:0] logData [256];
  int          logN;
  logic [7:0]  mem [512];
  int          fixCount;

  always @(posedge clk) begin
    logic [31:0] rd;
    logic [3:0] st;
    if (!rst_n) begin
      engAck <= 1'b0;
      engRdata <= '0;
    end else if (engAck) begin
      engAck <= 1'b0;
    end else if (engReq) begin
      engAck <= 1'b1;
      rd = '0;
      if (engWe) begin
        if (engAddr == 4'd10 && engWdata[0]) started = 1;
      end else begin
        case (engAddr)
          4'd1, 4'd2, 4'd3, 4'd4: rd = synReg[engAddr - 4'd1];
          4'd5: begin
            if (!started) st = 4'd3;
            else if (stIdx < seqLen) begin st = seq[stIdx]; stIdx++; end
            else begin st = finalSt; termSeen = 1; end
            rd = {14'h0, cntField, 4'h0, st, 8'h0};
            statusReads++;
          end
          4'd6: rd = addrReg[0];
          4'd7: rd = addrReg[1];
          4'd8: rd = valReg[0];
          4'd9: rd = valReg[1];
          default: rd = '0;
        endcase
        if (engAddr >= 4'd6 && engAddr <= 4'd9 && started && !termSeen) earlyRead++;
      end
      if (logN < 256) begin
        logSel[logN] = engAddr; logWe[logN] = engWe; logData[logN] = engWdata;
      end
      logN++;
      engRdata <= rd;
    end
  end

  always @(posedge clk) begin
    if (rst_n && bufFixValid) begin
      mem[bufFixIdx] = mem[bufFixIdx] ^ bufFixMask;
      fixCount++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setupRun(input logic [79:0] bytesV);
    for (int i = 0; i < 512; i++) mem[i] = 8'(i) ^ 8'h3C;
    for (int i = 0; i < 4; i++) synReg[i] = '0;
    addrReg[0] = '0; addrReg[1] = '0; valReg[0] = '0; valReg[1] = '0;
    seqLen = 0; finalSt = 4'd0; cntField = 2'd0;
    started = 0; termSeen = 0; stIdx = 0; statusReads = 0; earlyRead = 0;
    logN = 0; fixCount = 0;
    eccIn = bytesV;
  endtask

  task automatic runSeq(input string req);
    int lim;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    lim = 0;
    while (!done && lim < 3000) begin
      if (lim > 0 || !done) @(negedge clk);
      lim++;
    end
    check(done == 1'b1, req, "done seen", done, 1);
  endtask

  function automatic int changedBytes();
    int n = 0;
    for (int i = 0; i < 512; i++) if (mem[i] != (8'(i) ^ 8'h3C)) n++;
    return n;
  endfunction

  task automatic t_reset();
    check(done == 1'b0, "R9", "reset done", done, 0);
    check(corrected == 3'd0, "R9", "reset corrected", corrected, 0);
    check(uncorrectable == 1'b0, "R9", "reset uncorrectable", uncorrectable, 0);
    check(engReq == 1'b0, "R9", "reset engReq", engReq, 0);
  endtask

  task automatic t_erased();
    setupRun({10{8'hFF}});
    runSeq("R1");
    check(corrected == 3'd0, "R1", "erased corrected", corrected, 0);
    check(uncorrectable == 1'b0, "R1", "erased uncorr", uncorrectable, 0);
    check(logN == 0, "R1", "erased engine accesses", logN, 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done one cycle", done, 0);
  endtask

  task automatic t_load_order(input logic [79:0] bytesV, input string tag);
    int bad = 0;
    setupRun(bytesV);
    runSeq(tag);
    check(logN == 12, "R2", "accesses load+syn", logN, 12);
    for (int k = 0; k < 8; k++) begin
      logic [9:0] expV = bytesV[(7-k)*10 +: 10];
      if (!(logWe[k] && logSel[k] == 4'd0 && logData[k] == {22'h0, expV})) bad++;
    end
    check(bad == 0, "R2", "load writes wrong (count)", bad, 0);
    for (int k = 8; k < 12 && k < logN; k++)
      check(!logWe[k] && logSel[k] == 4'(k - 7), "R3", "syndrome read select", logSel[k], k - 7);
    check(corrected == 3'd0, "R3", "zero syndrome corrected", corrected, 0);
    check(!started, "R3", "start written on zero syndrome", started, 0);
  endtask

  task automatic t_single_wait();
    int ci = -1;
    setupRun(80'h0123_4567_89AB_CDEF_1357);
    synReg[2] = 32'h0000_0004;
    synReg[0] = 32'hFC00_FC00; // bits outside the kept fields
    seq[0] = 4'd3; seq[1] = 4'd3; seq[2] = 4'd3; seq[3] = 4'd9; seq[4] = 4'd9;
    seqLen = 5; finalSt = 4'd2; cntField = 2'd0;
    addrReg[0] = {6'h00, 10'd500, 6'h00, 10'd419};
    valReg[0] = {16'h0077, 16'h005A};
    runSeq("R5");
    for (int i = 0; i < logN && i < 256; i++) if (logWe[i] && logSel[i] == 4'd10) ci = i;
    check(ci > 0 && !logWe[ci-1] && logSel[ci-1] == 4'd6, "R4", "access before start", ci > 0 ? logSel[ci-1] : -1, 6);
    check(ci > 0 && logData[ci][0], "R4", "start bit", ci > 0 ? logData[ci][0] : 0, 1);
    check(statusReads == 6, "R5", "status reads", statusReads, 6);
    check(earlyRead == 0, "R5", "error reads before result", earlyRead, 0);
    check(corrected == 3'd1, "R8", "single corrected", corrected, 1);
    check(mem[100] == (8'd100 ^ 8'h3C ^ 8'h5A), "R8", "byte 100", mem[100], 8'd100 ^ 8'h3C ^ 8'h5A);
    check(changedBytes() == 1, "R7", "only one error used", changedBytes(), 1);
  endtask

  task automatic t_four();
    int bad = 0;
    logic [3:0] expSel [8] = '{4'd6, 4'd8, 4'd6, 4'd8, 4'd7, 4'd9, 4'd7, 4'd9};
    setupRun(80'h0);
    synReg[3] = 32'h0001_0000;
    seq[0] = 4'd12; seqLen = 1; finalSt = 4'd3; cntField = 2'd3;
    addrReg[0] = {6'h2A, 10'd8, 6'h3F, 10'd509};
    valReg[0]  = {8'hAB, 8'h42, 8'hCD, 8'h81};
    addrReg[1] = {6'h00, 10'd7, 6'h00, 10'd600};
    valReg[1]  = {8'h00, 8'h11, 8'h00, 8'h22};
    runSeq("R7");
    for (int k = 0; k < 8; k++) if (logSel[logN-8+k] != expSel[k]) bad++;
    check(bad == 0, "R7", "error register order mismatches", bad, 0);
    check(corrected == 3'd2, "R8", "four errors corrected", corrected, 2);
    check(mem[10] == (8'd10 ^ 8'h3C ^ 8'h81), "R7", "byte 10 low half", mem[10], 8'd10 ^ 8'h3C ^ 8'h81);
    check(mem[511] == (8'hFF ^ 8'h3C ^ 8'h42), "R7", "byte 511 upper half", mem[511], 8'hFF ^ 8'h3C ^ 8'h42);
    check(changedBytes() == 2, "R8", "out-of-range skipped", changedBytes(), 2);
    check(fixCount == 2, "R10", "fix strobes", fixCount, 2);
    repeat (3) @(negedge clk);
    check(corrected == 3'd2, "R9", "corrected held", corrected, 2);
  endtask

  task automatic t_final(input logic [3:0] fs, input bit expU);
    setupRun(80'h5);
    synReg[1] = 32'h0000_0200;
    seq[0] = 4'd5; seqLen = 1; finalSt = fs;
    runSeq("R6");
    check(uncorrectable == expU, "R6", "uncorrectable", uncorrectable, expU);
    check(corrected == 3'd0, "R6", "corrected", corrected, 0);
    check(!logWe[logN-1] && logSel[logN-1] == 4'd8, "R6", "flush read select", logSel[logN-1], 8);
    check(changedBytes() == 0, "R6", "buffer untouched", changedBytes(), 0);
  endtask

  task automatic t_timeout();
    setupRun(80'h9);
    synReg[0] = 32'h1;
    seqLen = 0; finalSt = 4'd2; cntField = 2'd0;
    addrReg[0] = {16'h0, 6'h0, 10'd519};
    valReg[0] = 32'h0000_0001;
    runSeq("R5");
    check(statusReads >= TMO/2 && statusReads <= TMO/2 + 4, "R5", "timeout status reads", statusReads, TMO/2 + 2);
    check(corrected == 3'd1, "R5", "after timeout corrected", corrected, 1);
    check(mem[0] == (8'h3C ^ 8'h01), "R8", "byte 0", mem[0], 8'h3C ^ 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErr++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks + 1);
    $finish;
  end

  initial begin
    setupRun('0);
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_erased();
    t_load_order(80'h1234_5678_9ABC_DEF0_2468, "R2");
    t_load_order({8'hFE, {9{8'hFF}}}, "R1");
    t_single_wait();
    t_four();
    t_final(4'd1, 1'b1);
    t_final(4'd0, 1'b0);
    t_timeout();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule